// File: doc/BRIEF.md
# 64-bit Countdown Timer with Register Port

This peripheral holds a 64-bit down-counter that a host programs through a single-cycle register port with 32-bit data. The host first writes a 64-bit start value as two 32-bit halves while the timer is stopped. It then sets the run bit in the control word. The start value is copied into the counter on the 0-to-1 change of the run bit, and the counter then steps down by one on every clock. When the counter is at zero on an active cycle, the timer expires and sets a sticky pending flag. In auto-reload mode the counter picks up the start value again on the same edge, so each period lasts start+1 cycles. In single-shot mode the counter stays at zero until the host stops and restarts it. The interrupt line is the pending flag gated by an unmask bit. The host clears the flag by writing a one to it.

The control path is a three-state machine. IDLE means stopped with the count frozen. RUN means counting. HOLD means expired in single-shot mode and parked at zero. Four transitions connect the states. Start (IDLE to RUN) happens when the run bit rises. Stop (RUN or HOLD to IDLE) happens when the run bit is cleared. Expire-reload (RUN to RUN) happens at zero in auto-reload mode. Expire-hold (RUN to HOLD) happens at zero in single-shot mode. The live count can be read as two halves with no snapshot latch. Software reads high, low, high and retries if the two high reads differ.

Top module: `cdtimer64`

## Requirements
- R1: The start value is readable at offset 0x00 (bits 31:0) and 0x04 (bits 63:32). The live count is readable at 0x08 (low half) and 0x0C (high half). Writes to 0x08 and 0x0C have no effect.
- R2: When control bit 0 (run) goes from 0 to 1, the counter loads the start value on that edge. While run stays 1, the counter drops by one per clock. Writing run=1 while it is already 1 does not reload the counter.
- R3: Clearing the run bit freezes the counter on that edge at its current value.
- R4: With control bit 1 = 0 (auto-reload), the edge on which the counter is zero sets the pending flag and reloads the start value. Expiries are therefore spaced start+1 cycles apart.
- R5: With control bit 1 = 1 (single-shot), the edge on which the counter is zero sets the pending flag once. The counter then stays at zero and the flag is not set again.
- R6: The irq output equals the pending flag AND control bit 2 (unmask). With bit 2 clear, the flag is still set and can still be read.
- R7: The pending flag reads as bit 0 at 0x18. Writing 1 to bit 0 clears it, and writing 0 has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: A high-low-high read sequence, retried while the two high reads differ, returns a 64-bit value equal to the live count at the low read. This holds even across a carry between the halves.
- R9: Reset clears the start value, the counter, the control word and the pending flag, and drives irq low.
- R10: The control word reads back at 0x10 in bits 2:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| irq | output | 1 | Pending flag gated by the unmask bit |

## Verification
Two functions can land on the same clock edge: the timer expiring, which sets the pending flag, and a host write-one that clears it. The bench programs an auto-reload period and counts edges from the start write. It then issues the clear so that the clear is sampled exactly on the expiry edge. It judges the result by reading the flag back, which must still be set. It then confirms that a write of zero leaves the flag alone and that a later clear, away from any expiry, does remove it.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } cdt_state_e;

    typedef struct packed {
        logic unmask;
        logic user_mode;
        logic enable;
    } cdt_ctl_t;

    localparam int CTL_W = 3;

    localparam logic [7:0] OFF_LOAD_LO = 8'h00;
    localparam logic [7:0] OFF_CNT_LO  = 8'h08;
    localparam logic [7:0] OFF_CTL     = 8'h10;
    localparam logic [7:0] OFF_STAT    = 8'h18;
    localparam int         WORD_STEP   = 4;

endpackage

// File: rtl/cdt_core.sv
`timescale 1ns/1ps
module cdt_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en_nxt,
    input  logic             start,
    input  logic             mode_user,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    cdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (start) begin
            state_d = S_RUN;
            cnt_d   = load_val;
        end else if (!en_nxt) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_RUN: begin
                    if (at_zero) begin
                        expire = 1'b1;
                        if (mode_user) begin
                            state_d = S_HOLD;
                        end else begin
                            cnt_d = load_val;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                S_HOLD: state_d = S_HOLD;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // outputs
    assign cnt = cnt_q;

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && en_nxt && !start && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_nxt) |=> $stable(cnt_q));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && en_nxt && !mode_user && at_zero) |=> (cnt_q == $past(load_val)));

    // R5
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && en_nxt && !start) |=> (cnt_q == '0 && !expire));

endmodule

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output logic [CNT_W-1:0]  load_val,
    output logic              en_nxt,
    output logic              mode_nxt,
    output logic              start,
    output logic              irq
);

    localparam int WORDS = CNT_W / DATA_W;
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    logic [CNT_W-1:0] load_q;
    cdt_ctl_t         ctl_q, ctl_d;
    logic             stat_q;
    logic             wr, ctl_wr, stat_clr;

    assign wr       = bus_sel & bus_we;
    assign ctl_wr   = wr && (bus_addr == A_CTL);
    assign stat_clr = wr && (bus_addr == A_STAT) && bus_wdata[0];

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = cdt_ctl_t'(bus_wdata[CTL_W-1:0]);
    end

    assign en_nxt   = ctl_d.enable;
    assign mode_nxt = ctl_d.user_mode;
    assign start    = ctl_d.enable & ~ctl_q.enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            ctl_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr && bus_addr == ADDR_W'(OFF_LOAD_LO) + ADDR_W'(WORD_STEP * w))
                    load_q[w*DATA_W +: DATA_W] <= bus_wdata;
            end
            ctl_q <= ctl_d;
            if (expire)        stat_q <= 1'b1;
            else if (stat_clr) stat_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(OFF_LOAD_LO) + ADDR_W'(WORD_STEP * w))
                bus_rdata = load_q[w*DATA_W +: DATA_W];
            if (bus_addr == ADDR_W'(OFF_CNT_LO) + ADDR_W'(WORD_STEP * w))
                bus_rdata = cnt[w*DATA_W +: DATA_W];
        end
        if (bus_addr == A_CTL)  bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
        if (bus_addr == A_STAT) bus_rdata = {{(DATA_W-1){1'b0}}, stat_q};
    end

    assign load_val = load_q;
    assign irq      = stat_q & ctl_q.unmask;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> stat_q);

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !expire) |=> !stat_q);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_d.unmask) |=> !irq);

endmodule

// File: rtl/cdtimer64.sv
`timescale 1ns/1ps
module cdtimer64
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] load_val, cnt;
    logic             en_nxt, mode_nxt, start, expire;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .expire    (expire),
        .load_val  (load_val),
        .en_nxt    (en_nxt),
        .mode_nxt  (mode_nxt),
        .start     (start),
        .irq       (irq)
    );

    cdt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_val  (load_val),
        .en_nxt    (en_nxt),
        .start     (start),
        .mode_user (mode_nxt),
        .cnt       (cnt),
        .expire    (expire)
    );

endmodule

// File: tb/cdtimer64_test.sv
`timescale 1ns/1ps
module cdtimer64_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          edge_n = 0;
    int          n_chk = 0;
    int          n_err = 0;

    localparam logic [4:0]  A_LLO = 5'h00, A_LHI = 5'h04, A_CLO = 5'h08;
    localparam logic [4:0]  A_CHI = 5'h0C, A_CTL = 5'h10, A_ST  = 5'h18;
    localparam logic [31:0] C_EN = 32'd1, C_USER = 32'd2, C_UNM = 32'd4;

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    cdtimer64 uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called between edges; write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d, output int k);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata; k = edge_n;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        for (int i = 0; i < 64; i++) begin
            if (irq) break;
            @(negedge clk);
        end
        t = edge_n;
    endtask

    task automatic stop_all();
        wr(A_CTL, 32'd0);
        wr(A_ST, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d; int k;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 irq after reset", irq, 0);
        rd(A_LLO, d, k); check("R9 start low", d, 0);
        rd(A_LHI, d, k); check("R9 start high", d, 0);
        rd(A_CLO, d, k); check("R9 count low", d, 0);
        rd(A_CHI, d, k); check("R9 count high", d, 0);
        rd(A_CTL, d, k); check("R9 control", d, 0);
        rd(A_ST, d, k);  check("R9 pending", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d; int k;
        wr(A_LLO, 32'hDEAD_BEEF);
        wr(A_LHI, 32'h0123_4567);
        rd(A_LLO, d, k); check("R1 start low readback", d, 32'hDEAD_BEEF);
        rd(A_LHI, d, k); check("R1 start high readback", d, 32'h0123_4567);
        wr(A_CLO, 32'h5555_5555);
        wr(A_CHI, 32'hAAAA_AAAA);
        rd(A_CLO, d, k); check("R1 count low write ignored", d, 0);
        rd(A_CHI, d, k); check("R1 count high write ignored", d, 0);
        wr(A_CTL, 32'hFFFF_FFF6);
        rd(A_CTL, d, k); check("R10 control readback", d, 6);
        wr(A_CTL, 32'd0);
    endtask

    task automatic t_free();
        logic [31:0] d; int k, t, e0;
        wr(A_LLO, 32'd3); wr(A_LHI, 32'd0);
        wr(A_CTL, C_EN | C_UNM); e0 = edge_n;
        rd(A_CLO, d, k); check("R2 loaded on start", d, 64'(3 - (k - e0)));
        rd(A_CLO, d, k); check("R2 one step per clock", d, 64'(3 - (k - e0)));
        wait_irq(t); check("R4 first expiry edge", 64'(t - e0), 4);
        rd(A_CLO, d, k); check("R4 reloaded after expiry", d, 3);
        wr(A_ST, 32'd1); check("R7 clear drops irq", irq, 0);
        wait_irq(t); check("R4 period start+1", 64'(t - e0), 8);
        stop_all();
    endtask

    task automatic t_user();
        logic [31:0] d; int k, t, e0;
        wr(A_LLO, 32'd2); wr(A_LHI, 32'd0);
        wr(A_CTL, C_EN | C_USER | C_UNM); e0 = edge_n;
        wait_irq(t); check("R5 single-shot expiry edge", 64'(t - e0), 3);
        rd(A_CLO, d, k); check("R5 parked at zero", d, 0);
        wr(A_ST, 32'd1);
        repeat (6) @(negedge clk);
        check("R5 no second expiry irq", irq, 0);
        rd(A_ST, d, k);  check("R5 no second expiry flag", d, 0);
        rd(A_CLO, d, k); check("R5 still zero low", d, 0);
        rd(A_CHI, d, k); check("R5 still zero high", d, 0);
        stop_all();
    endtask

    task automatic t_mask();
        logic [31:0] d; int k, e0;
        wr(A_LLO, 32'd1); wr(A_LHI, 32'd0);
        wr(A_CTL, C_EN); e0 = edge_n;
        repeat (3) @(negedge clk);
        rd(A_ST, d, k); check("R6 flag set while masked", d, 1);
        check("R6 masked irq low", irq, 0);
        wr(A_CTL, C_EN | C_UNM);
        check("R6 unmask raises irq", irq, 1);
        rd(A_CLO, d, k);
        check("R2 re-enable kept counting", d, ((k - e0) % 2 == 0) ? 64'd1 : 64'd0);
        stop_all();
    endtask

    task automatic t_freeze();
        logic [31:0] d; int k, e0, e1; logic [63:0] held;
        wr(A_LLO, 32'd1000); wr(A_LHI, 32'd0);
        wr(A_CTL, C_EN); e0 = edge_n;
        repeat (5) @(negedge clk);
        wr(A_LLO, 32'd50);
        wr(A_CTL, C_EN);
        rd(A_CLO, d, k); check("R2 run=1 again no reload", d, 64'(1000 - (k - e0)));
        held = 64'(1000 - (edge_n - e0));
        wr(A_CTL, 32'd0);
        repeat (3) @(negedge clk);
        rd(A_CLO, d, k); check("R3 frozen on stop", d, held);
        wr(A_CTL, C_EN); e1 = edge_n;
        rd(A_CLO, d, k); check("R2 restart takes new start", d, 64'(50 - (k - e1)));
        stop_all();
    endtask

    task automatic t_collide();
        logic [31:0] d; int k, e0;
        wr(A_LLO, 32'd7); wr(A_LHI, 32'd0);
        wr(A_CTL, C_EN | C_UNM); e0 = edge_n;
        while (edge_n < e0 + 7) @(negedge clk);
        wr(A_ST, 32'd1);
        rd(A_ST, d, k); check("R7 expiry wins over clear", d, 1);
        wr(A_ST, 32'd0);
        rd(A_ST, d, k); check("R7 write zero no effect", d, 1);
        wr(A_ST, 32'd1);
        rd(A_ST, d, k); check("R7 write one clears", d, 0);
        stop_all();
    endtask

    task automatic t_wide();
        logic [31:0] h1, h2, lo; int k, klo, e0, retries;
        logic [63:0] start_v;
        start_v = 64'h0000_0001_0000_0001;
        wr(A_LLO, start_v[31:0]); wr(A_LHI, start_v[63:32]);
        wr(A_CTL, C_EN); e0 = edge_n;
        retries = 0;
        do begin
            rd(A_CHI, h1, k);
            rd(A_CLO, lo, klo);
            rd(A_CHI, h2, k);
            if (h1 != h2) retries++;
        end while (h1 != h2 && retries < 4);
        check("R8 consistent 64-bit value", {h2, lo}, start_v - 64'(klo - e0));
        check("R8 carry forced one retry", 64'(retries), 1);
        stop_all();
    endtask

    initial begin
        #900000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_free();
        t_user();
        t_mask();
        t_freeze();
        t_collide();
        t_wide();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule